// File: doc/BRIEF.md
# Disk Block Transfer Controller

This block models a simple disk as a small on-chip block store and moves whole blocks between it and primary store. Software programs it through four word-wide registers: a command register, a block-number register, a primary-store address register and a status register. Writing a command captures the current block number and address. After a configurable start delay, which stands in for seek and rotation time, the controller copies one block word by word over a request/grant memory master port.

Every command completes with a status code and a one-cycle disk interrupt, whether it succeeded or failed. A command written while another is still running cancels the older one. Only the replacing command raises an interrupt. The store holds `BLOCK_COUNT` blocks of `BLOCK_WORDS` words each. User space is the address window `[USER_BASE, USER_BASE+USER_SIZE)`.

Top module: `disk_dma_ctrl`

## Requirements
- R1: After reset the status register reads 0 (ok), `disk_irq` is low and `mem_req` is low.
- R2: Register offsets on `reg_sel` are: 0 command, 1 block number, 2 address, 3 status. The command register always reads 0. The block and address registers read back the last value written to them.
- R3: Command code 1 (disk to memory) writes the block named by the captured block number into primary store at the captured address and the `BLOCK_WORDS-1` words after it (`mem_we`=1). It completes with status 0.
- R4: Command code 2 (memory to disk) reads `BLOCK_WORDS` consecutive primary-store words, starting at the captured address, into the captured block (`mem_we`=0). It completes with status 0.
- R5: Any other command code completes with status 1 (bad command) and issues no memory request. This check takes priority over R6 and R7.
- R6: A block number of `BLOCK_COUNT` or more completes with status 2 (bad block) and issues no memory request. This check takes priority over R7.
- R7: A start address below `USER_BASE`, or one where `address + BLOCK_WORDS` exceeds `USER_BASE + USER_SIZE`, completes with status 3 (bad address) and issues no memory request.
- R8: The block number and address are captured when the command is written. Writes to those registers afterwards do not change the running operation.
- R9: A command write during an operation cancels that operation, whether or not the new command is valid. Only the new command raises an interrupt. `mem_req` is low in the cycle after any command write.
- R10: Each command that is not cancelled produces exactly one `disk_irq` pulse, one cycle wide. The status register changes only in the cycle `disk_irq` is high.
- R11: The first `mem_req` of a valid command rises `START_DELAY+1` clock edges after the command-write edge. Exactly one word moves per cycle with `mem_req` and `mem_gnt` both high. While it waits for a grant, the request and its address hold steady.
- R12: Every memory request address lies inside user space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register offset |
| reg_wdata | input | WORD_W | Register write data |
| reg_rdata | output | WORD_W | Register read data for `reg_sel` (combinational) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1: write to primary store, 0: read from it |
| mem_addr | output | WORD_W | Primary-store word address |
| mem_wdata | output | WORD_W | Data written to primary store |
| mem_gnt | input | 1 | Grant; a word moves when request and grant are both high |
| mem_rdata | input | WORD_W | Primary-store read data, valid alongside the grant |
| disk_irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench aborts transfers after several words have already moved, both with a valid command and with an illegal one. A design that let the old operation finish would raise two interrupts or leave the wrong block in memory. It rewrites the block and address registers right after a command. A design that read them live would deliver the data to the second address. It also probes the address limits one word on each side of user space and combines errors, so a wrong priority order shows up as the wrong status code. Grants come at random, so a controller that advanced its word index without a grant would leave the copied block skewed.

// File: rtl/disk_pkg.sv
package disk_pkg;

    // register offsets on the programming port
    localparam logic [1:0] OFS_CMD  = 2'd0;
    localparam logic [1:0] OFS_BLK  = 2'd1;
    localparam logic [1:0] OFS_ADDR = 2'd2;
    localparam logic [1:0] OFS_STAT = 2'd3;

    // command codes
    localparam int CMD_TO_MEM   = 1;
    localparam int CMD_FROM_MEM = 2;

    typedef enum logic [1:0] {
        STS_OK        = 2'd0,
        STS_BAD_CMD   = 2'd1,
        STS_BAD_BLOCK = 2'd2,
        STS_BAD_ADDR  = 2'd3
    } disk_sts_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_MOVE,
        ST_FINISH
    } xfer_st_e;

    // true when [start, start+len) lies inside [base, base+size)
    function automatic logic span_fits(input int unsigned start,
                                       input int unsigned base,
                                       input int unsigned size,
                                       input int unsigned len);
        return (start >= base) && (start + len <= base + size);
    endfunction

endpackage

// File: rtl/disk_reg_file.sv
module disk_reg_file
    import disk_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    input  disk_sts_e         status,
    output logic              cmd_wr,
    output logic [WORD_W-1:0] blk_arg,
    output logic [WORD_W-1:0] addr_arg,
    output logic [WORD_W-1:0] reg_rdata
);

    assign cmd_wr = reg_wr && (reg_sel == OFS_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_arg  <= '0;
            addr_arg <= '0;
        end else if (reg_wr) begin
            if (reg_sel == OFS_BLK)  blk_arg  <= reg_wdata;
            if (reg_sel == OFS_ADDR) addr_arg <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_sel)
            OFS_BLK:  reg_rdata = blk_arg;
            OFS_ADDR: reg_rdata = addr_arg;
            OFS_STAT: reg_rdata = WORD_W'(status);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/disk_block_store.sv
module disk_block_store #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wdata;
    end

    assign rdata = cells[idx];

    // R4: a store write only ever targets an existing cell
    p_store_idx_r4: assert property (@(posedge clk) disable iff (rst)
        we |-> (32'(idx) < DEPTH));

endmodule

// File: rtl/disk_xfer_fsm.sv
module disk_xfer_fsm
    import disk_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int BLOCK_COUNT = 8,
    parameter int BLOCK_WORDS = 8,
    parameter int USER_BASE   = 1024,
    parameter int USER_SIZE   = 1024,
    parameter int START_DELAY = 3,
    localparam int DEPTH      = BLOCK_COUNT * BLOCK_WORDS,
    localparam int SIDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int BLK_W      = (BLOCK_COUNT > 1) ? $clog2(BLOCK_COUNT) : 1,
    localparam int OFF_W      = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1,
    localparam int DLY_W      = (START_DELAY > 0) ? $clog2(START_DELAY + 1) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_code,
    input  logic [WORD_W-1:0] blk_arg,
    input  logic [WORD_W-1:0] addr_arg,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              st_we,
    output logic [SIDX_W-1:0] st_idx,
    output logic [WORD_W-1:0] st_wdata,
    input  logic [WORD_W-1:0] st_rdata,
    output disk_sts_e         status,
    output logic              irq
);

    xfer_st_e          state_q;
    logic              to_mem_q;
    logic [BLK_W-1:0]  blk_q;
    logic [WORD_W-1:0] base_q;
    logic [OFF_W-1:0]  off_q;
    logic [DLY_W-1:0]  dly_q;
    disk_sts_e         code_q;
    disk_sts_e         status_q;
    logic              irq_q;

    // command decode, in priority order: code, block, address
    logic      is_to_mem, is_from_mem, blk_ok, addr_ok;
    disk_sts_e new_code;

    always_comb begin
        is_to_mem   = (cmd_code == WORD_W'(CMD_TO_MEM));
        is_from_mem = (cmd_code == WORD_W'(CMD_FROM_MEM));
        blk_ok      = (32'(blk_arg) < BLOCK_COUNT);
        addr_ok     = span_fits(32'(addr_arg), USER_BASE, USER_SIZE, BLOCK_WORDS);
        if (!(is_to_mem || is_from_mem)) new_code = STS_BAD_CMD;
        else if (!blk_ok)                new_code = STS_BAD_BLOCK;
        else if (!addr_ok)               new_code = STS_BAD_ADDR;
        else                             new_code = STS_OK;
    end

    logic handshake, last_word;
    assign mem_req   = (state_q == ST_MOVE) && !cmd_wr;
    assign handshake = mem_req && mem_gnt;
    assign last_word = (off_q == OFF_W'(BLOCK_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            to_mem_q <= 1'b0;
            blk_q    <= '0;
            base_q   <= '0;
            off_q    <= '0;
            dly_q    <= '0;
            code_q   <= STS_OK;
            status_q <= STS_OK;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (cmd_wr) begin
                // a new command replaces whatever was running
                to_mem_q <= is_to_mem;
                blk_q    <= BLK_W'(blk_arg);
                base_q   <= addr_arg;
                off_q    <= '0;
                dly_q    <= '0;
                code_q   <= new_code;
                state_q  <= (new_code == STS_OK) ? ST_WAIT : ST_FINISH;
            end else begin
                unique case (state_q)
                    ST_WAIT: begin
                        if (dly_q == DLY_W'(START_DELAY)) state_q <= ST_MOVE;
                        else                              dly_q   <= dly_q + DLY_W'(1);
                    end
                    ST_MOVE: begin
                        if (handshake) begin
                            if (last_word) state_q <= ST_FINISH;
                            else           off_q   <= off_q + OFF_W'(1);
                        end
                    end
                    ST_FINISH: begin
                        status_q <= code_q;
                        irq_q    <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign mem_we    = to_mem_q;
    assign mem_addr  = base_q + WORD_W'(off_q);
    assign mem_wdata = st_rdata;
    assign st_idx    = SIDX_W'(32'(blk_q) * BLOCK_WORDS + 32'(off_q));
    assign st_we     = handshake && !to_mem_q;
    assign st_wdata  = mem_rdata;
    assign status    = status_q;
    assign irq       = irq_q;

    // R10: the completion interrupt lasts one cycle
    p_irq_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    // R10: status only changes together with the interrupt
    p_status_with_irq_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_q) |-> irq_q);

    // R9: a command write stops any request in the following cycle
    p_cmd_halts_req_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> !mem_req);

    // R11: an ungranted request stays up (unless cancelled) with a fixed address
    p_req_held_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> ((mem_req || cmd_wr) && $stable(mem_addr)));

    // R12: requests stay within user space
    p_req_in_user_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ((32'(mem_addr) >= USER_BASE) &&
                     (32'(mem_addr) < USER_BASE + USER_SIZE)));

endmodule

// File: rtl/disk_dma_ctrl.sv
module disk_dma_ctrl
    import disk_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int BLOCK_COUNT = 8,
    parameter int BLOCK_WORDS = 8,
    parameter int USER_BASE   = 1024,
    parameter int USER_SIZE   = 1024,
    parameter int START_DELAY = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              disk_irq
);

    localparam int DEPTH  = BLOCK_COUNT * BLOCK_WORDS;
    localparam int SIDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              cmd_wr;
    logic [WORD_W-1:0] blk_arg, addr_arg;
    disk_sts_e         status;
    logic              st_we;
    logic [SIDX_W-1:0] st_idx;
    logic [WORD_W-1:0] st_wdata, st_rdata;

    disk_reg_file #(.WORD_W(WORD_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .status   (status),
        .cmd_wr   (cmd_wr),
        .blk_arg  (blk_arg),
        .addr_arg (addr_arg),
        .reg_rdata(reg_rdata)
    );

    disk_xfer_fsm #(
        .WORD_W     (WORD_W),
        .BLOCK_COUNT(BLOCK_COUNT),
        .BLOCK_WORDS(BLOCK_WORDS),
        .USER_BASE  (USER_BASE),
        .USER_SIZE  (USER_SIZE),
        .START_DELAY(START_DELAY)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_code (reg_wdata),
        .blk_arg  (blk_arg),
        .addr_arg (addr_arg),
        .mem_gnt  (mem_gnt),
        .mem_rdata(mem_rdata),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .st_we    (st_we),
        .st_idx   (st_idx),
        .st_wdata (st_wdata),
        .st_rdata (st_rdata),
        .status   (status),
        .irq      (disk_irq)
    );

    disk_block_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk  (clk),
        .rst  (rst),
        .we   (st_we),
        .idx  (st_idx),
        .wdata(st_wdata),
        .rdata(st_rdata)
    );

endmodule

// File: tb/test_disk_dma_ctrl.sv
module test_disk_dma_ctrl;

    localparam int W    = 16;
    localparam int BC   = 8;
    localparam int BW   = 8;
    localparam int UB   = 1024;
    localparam int US   = 1024;
    localparam int DLY  = 3;
    localparam int MEMN = 2048;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic          mem_req, mem_we;
    logic [W-1:0]  mem_addr, mem_wdata, mem_rdata;
    logic          mem_gnt = 1'b0;
    logic          disk_irq;

    logic [W-1:0]  pmem [MEMN];
    logic [W-1:0]  dmodel [BC][BW];

    int nvec = 0, nfail = 0;
    int irq_cnt = 0, hs_cnt = 0, req_cnt = 0;
    int gnt_mode = 0;

    always #5 clk = ~clk;

    disk_dma_ctrl i_disk_dma_ctrl (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .disk_irq(disk_irq)
    );

    assign mem_rdata = pmem[mem_addr[10:0]];

    // primary-store model, grant source and event counters
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            case (gnt_mode)
                1:       mem_gnt = 1'b1;
                2:       mem_gnt = (($urandom % 4) == 0);
                default: mem_gnt = (($urandom % 4) != 0);
            endcase
            if (disk_irq) irq_cnt++;
            if (mem_req) req_cnt++;
            if (mem_req && mem_gnt) begin
                hs_cnt++;
                if (mem_we) pmem[mem_addr[10:0]] = mem_wdata;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] s, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = W'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] s, output int v);
        @(negedge clk);
        #3;
        reg_sel = s;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wait_irq(input int pre);
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk); #3;
            if (irq_cnt != pre) break;
        end
        repeat (4) @(negedge clk);
        #3;
    endtask

    function automatic int exp_status(input int code, input int blk, input int addr);
        if (code != 1 && code != 2) return 1;
        if (blk >= BC) return 2;
        if (addr < UB || addr + BW > UB + US) return 3;
        return 0;
    endfunction

    // full command: checks interrupt count, status, word count, delay and data
    task automatic issue(input int code, input int blk, input int addr, input string req);
        int pre_irq, pre_hs, pre_req, st, es, n, bad;
        es = exp_status(code, blk, addr);
        pre_irq = irq_cnt; pre_hs = hs_cnt; pre_req = req_cnt;
        if (es == 0 && code == 2)
            for (int i = 0; i < BW; i++) dmodel[blk][i] = pmem[addr + i];
        reg_write(1, blk);
        reg_write(2, addr);
        reg_write(0, code);
        if (es == 0) begin
            n = 0;
            for (int k = 0; k < 50; k++) begin
                #1;
                if (mem_req) break;
                @(negedge clk);
                n++;
            end
            chk(n == DLY + 1, "R11 start delay", n, DLY + 1);
        end
        wait_irq(pre_irq);
        chk(irq_cnt == pre_irq + 1, {req, " R10 irq count"}, irq_cnt - pre_irq, 1);
        reg_read(3, st);
        chk(st == es, {req, " status"}, st, es);
        if (es == 0) begin
            chk(hs_cnt - pre_hs == BW, {req, " R11 words moved"}, hs_cnt - pre_hs, BW);
            if (code == 1) begin
                bad = 0;
                for (int i = 0; i < BW; i++) if (pmem[addr + i] !== dmodel[blk][i]) bad++;
                chk(bad == 0, {req, " R3 block data"}, bad, 0);
            end
        end else begin
            chk(req_cnt == pre_req, {req, " no request on error"}, req_cnt - pre_req, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int v, pre, a, b, c, bad, code, blk, addr, pick;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < MEMN; i++) pmem[i] = W'($urandom);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #3;
        chk(disk_irq == 1'b0, "R1 irq", int'(disk_irq), 0);
        chk(mem_req == 1'b0, "R1 req", int'(mem_req), 0);
        reg_read(3, v);
        chk(v == 0, "R1 status", v, 0);

        // R2 register map
        reg_write(1, 5);
        reg_write(2, 16'h0456);
        reg_read(1, v); chk(v == 5, "R2 block readback", v, 5);
        reg_read(2, v); chk(v == 16'h0456, "R2 address readback", v, 16'h0456);
        reg_read(0, v); chk(v == 0, "R2 command reads zero", v, 0);

        // R4: load every block from memory, R3: read each back elsewhere
        for (int b2 = 0; b2 < BC; b2++) issue(2, b2, UB + 40 * b2, "R4 init");
        for (int b2 = 0; b2 < BC; b2++) issue(1, b2, UB + 600 + 9 * b2, "R3 readout");

        // address and block boundaries, error priority (R5 R6 R7)
        gnt_mode = 1;
        issue(1, 0, UB + US - BW, "R7 top edge ok");
        issue(1, 0, UB + US - BW + 1, "R7 past top");
        issue(1, 0, UB, "R7 base ok");
        issue(1, 0, UB - 1, "R7 below base");
        issue(1, BC - 1, UB + 100, "R6 last block ok");
        issue(1, BC, UB + 100, "R6 block count");
        issue(0, 0, UB, "R5 code zero");
        issue(3, 0, UB, "R5 code three");
        issue(7, BC, 5, "R5 priority over block");
        issue(2, BC + 3, 5, "R6 priority over address");
        gnt_mode = 0;

        // R8: arguments captured at command time
        pre = irq_cnt;
        a = UB + 300; b = UB + 700;
        for (int i = 0; i < BW; i++) pmem[b + i] = 16'hBEEF;
        reg_write(1, 1); reg_write(2, a); reg_write(0, 1);
        reg_write(1, 5); reg_write(2, b);
        wait_irq(pre);
        bad = 0;
        for (int i = 0; i < BW; i++) if (pmem[a + i] !== dmodel[1][i]) bad++;
        chk(bad == 0, "R8 data at captured address", bad, 0);
        bad = 0;
        for (int i = 0; i < BW; i++) if (pmem[b + i] !== 16'hBEEF) bad++;
        chk(bad == 0, "R8 later address untouched", bad, 0);
        reg_read(1, v); chk(v == 5, "R8 block register rewritten", v, 5);

        // R9: abort a running transfer with a valid command
        gnt_mode = 2;
        pre = irq_cnt;
        a = UB + 100; b = UB + 500;
        for (int i = 0; i < BW; i++) pmem[b + i] = 16'h0;
        reg_write(1, 2); reg_write(2, a); reg_write(0, 2);
        reg_write(1, 3); reg_write(2, b);
        v = hs_cnt;
        for (int k = 0; k < 500 && hs_cnt < v + 3; k++) @(negedge clk);
        reg_write(0, 1);
        wait_irq(pre);
        chk(irq_cnt == pre + 1, "R9 single irq after abort", irq_cnt - pre, 1);
        reg_read(3, v); chk(v == 0, "R9 status of replacement", v, 0);
        bad = 0;
        for (int i = 0; i < BW; i++) if (pmem[b + i] !== dmodel[3][i]) bad++;
        chk(bad == 0, "R9 replacement data", bad, 0);

        // R9: abort with an illegal command
        pre = irq_cnt;
        c = UB + 800;
        reg_write(1, 0); reg_write(2, c); reg_write(0, 1);
        v = hs_cnt;
        for (int k = 0; k < 500 && hs_cnt < v + 2; k++) @(negedge clk);
        reg_write(0, 9);
        wait_irq(pre);
        chk(irq_cnt == pre + 1, "R9 single irq after bad abort", irq_cnt - pre, 1);
        reg_read(3, v); chk(v == 1, "R9 bad command status", v, 1);
        gnt_mode = 0;
        issue(2, 2, UB + 100, "R4 restore block");

        // random mix of valid and faulty commands
        for (int it = 0; it < 40; it++) begin
            pick = int'($urandom % 8);
            code = (($urandom % 2) == 0) ? 1 : 2;
            blk  = int'($urandom % BC);
            addr = UB + int'($urandom % (US - BW + 1));
            if (pick == 0) code = 3 + int'($urandom % 100);
            if (pick == 1) blk = BC + int'($urandom % 50);
            if (pick == 2) addr = (($urandom % 2) == 0) ? int'($urandom % UB)
                                                        : UB + US - BW + 1 + int'($urandom % (BW + 20));
            gnt_mode = int'($urandom % 3);
            issue(code, blk, addr, "R3/R4 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule